// File: doc/BRIEF.md
# IO Rail Deep Power-Down Controller

This controller moves a single IO pad rail into or out of deep power-down when a request arrives. The pad rails are grouped into banks of 32-bit request words. In each word the low 30 bits pick rails and the top two bits carry a command code. The controller splits a 7-bit rail identifier into a bank and a bit position, and it refuses identifiers that do not name a real rail. For a legal request it first raises a sampling enable and loads a minimum-hold timer. It then writes the request word and watches the rail's status bit until the status reaches the wanted level or a cycle budget runs out.

Only one request is in flight at a time. The owner pulses `req_valid_i` together with a rail identifier and a direction. It then waits for one of three one-cycle outcome pulses: done, timeout or invalid. The minimum-hold value is fixed at elaboration from the APB clock frequency, so that the hold is at least 200 ns.

Top module: `dpd_rail_ctrl`

## Requirements
- R1: A rail ID selects bank `id / 32` and bit `id % 32`. Bank 0 drives `req_flat_o[31:0]` and reads `status_flat_i[31:0]`. Bank 1 drives `req_flat_o[63:32]` and reads `status_flat_i[63:32]`.
- R2: An ID of 64 or more, or any ID whose bit position is 30 or 31, is invalid. It gives a one-cycle `err_inval_o` pulse on the cycle after acceptance. `busy_o` stays low and the request words do not change.
- R3: Writing a request sets the rail's bit in its bank word and replaces bits [31:30] of that word with the command code. The code is 1 when powering the rail up (`req_on_i`=1) and 2 when powering it down (`req_on_i`=0). Rail bits set earlier are kept, the other bank is untouched, and code 3 never appears.
- R4: `sample_en_o` rises on the cycle after a legal request is accepted, which is one cycle before the request word changes. It falls on the cycle the done or timeout pulse appears. The request words change only while `sample_en_o` is high.
- R5: While `sample_en_o` is high, `dpd_timer_o` holds ceil(200 / ceil(1e9 / PCLK_HZ)).
- R6: Powering up waits until the rail's status bit reads 0, and powering down waits until it reads 1. Status is first compared two cycles after acceptance. If the status matches by then, `done_o` pulses three cycles after acceptance. Otherwise `done_o` pulses the cycle after the first matching comparison.
- R7: If the status has not matched after TIMEOUT_CYCLES comparisons, `err_timeout_o` pulses TIMEOUT_CYCLES+2 cycles after acceptance. At most one of the three outcome pulses is high in any cycle.
- R8: `busy_o` is high from the cycle after acceptance until the outcome pulse. A request presented while busy is ignored.
- R9: After reset `busy_o`, `sample_en_o`, the outcome pulses, `dpd_timer_o` and both request words are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | APB clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_id_i | input | 7 | Rail identifier |
| req_on_i | input | 1 | 1 = power rail up, 0 = power rail down |
| status_flat_i | input | 64 | Per-rail status from the pads, both banks |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Status reached target (pulse) |
| err_timeout_o | output | 1 | Wait budget exhausted (pulse) |
| err_inval_o | output | 1 | Rejected identifier (pulse) |
| sample_en_o | output | 1 | Pad sampling enable |
| dpd_timer_o | output | 16 | Minimum-hold count in APB cycles |
| req_flat_o | output | 64 | Request words, both banks |

## Verification
The bench builds the block with PCLK_HZ = 30 MHz and TIMEOUT_CYCLES = 40. At 30 MHz the 1e9/PCLK_HZ step rounds up from 33.3 to 34 ns, so the hold value is 6. With a budget of 40 cycles, a pad latency of 41 still completes and a latency of 42 times out, so both sides of the timeout edge are checked within a few dozen cycles. The bench's pad model sets each status bit after a chosen latency, which covers both banks, both directions, already-matching status and the rejected control-bit identifiers.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_EXIT  = 2'd1,
    CMD_ENTER = 2'd2
  } dpd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAIT
  } dpd_state_e;

  // ceil(200 ns / ceil(period in ns))
  function automatic int min_hold_cycles(longint unsigned hz);
    longint unsigned ns;
    ns = (64'd1_000_000_000 + hz - 64'd1) / hz;
    return int'((64'd200 + ns - 64'd1) / ns);
  endfunction
endpackage

// File: rtl/dpd_id_decode.sv
module dpd_id_decode #(
  parameter int NUM_BANKS = 2,
  parameter int WORD_W    = 32,
  parameter int RAIL_BITS = 30,
  parameter int ID_W      = 7,
  parameter int BIT_W     = 5,
  parameter int BANK_W    = 1
) (
  input  logic [ID_W-1:0]   id_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              valid_o
);
  logic [ID_W-BIT_W-1:0] bank_full;

  assign bank_full = id_i[ID_W-1:BIT_W];
  assign bank_o    = bank_full[BANK_W-1:0];
  assign bit_o     = id_i[BIT_W-1:0];
  assign valid_o   = (int'(bank_full) < NUM_BANKS) && (int'(bit_o) < RAIL_BITS);
endmodule

// File: rtl/dpd_bank_reg.sv
module dpd_bank_reg #(
  parameter int WORD_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [1:0]        cmd_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
    end else if (wr_i) begin
      word_o[bit_i]          <= 1'b1;
      word_o[WORD_W-1 -: 2]  <= cmd_i;
    end
  end
endmodule

// File: rtl/dpd_seq.sv
module dpd_seq
  import dpd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int TIMER_W        = 16,
  parameter int TIMER_VAL      = 20,
  parameter int BIT_W          = 5,
  parameter int BANK_W         = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               id_valid_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [BIT_W-1:0]   bit_i,
  input  logic               on_i,
  input  logic               status_bit_i,
  output logic [BANK_W-1:0]  cur_bank_o,
  output logic [BIT_W-1:0]   cur_bit_o,
  output logic [1:0]         cmd_o,
  output logic               wr_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_timeout_o,
  output logic               err_inval_o,
  output logic               sample_en_o,
  output logic [TIMER_W-1:0] timer_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  dpd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cur_on_q;
  logic             target;

  assign target = ~cur_on_q;  // up waits for 0, down waits for 1
  assign cmd_o  = cur_on_q ? CMD_EXIT : CMD_ENTER;
  assign wr_o   = (state_q == ST_PREP);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      cur_on_q      <= 1'b0;
      cur_bank_o    <= '0;
      cur_bit_o     <= '0;
      done_o        <= 1'b0;
      err_timeout_o <= 1'b0;
      err_inval_o   <= 1'b0;
      sample_en_o   <= 1'b0;
      timer_o       <= '0;
    end else begin
      done_o        <= 1'b0;
      err_timeout_o <= 1'b0;
      err_inval_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (id_valid_i) begin
              state_q     <= ST_PREP;
              sample_en_o <= 1'b1;
              timer_o     <= TIMER_W'(TIMER_VAL);
              cur_bank_o  <= bank_i;
              cur_bit_o   <= bit_i;
              cur_on_q    <= on_i;
            end else begin
              err_inval_o <= 1'b1;
            end
          end
        end
        ST_PREP: begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end
        ST_WAIT: begin
          if (status_bit_i == target) begin
            done_o      <= 1'b1;
            sample_en_o <= 1'b0;
            state_q     <= ST_IDLE;
          end else if (cnt_q == CNT_W'(TIMEOUT_CYCLES - 1)) begin
            err_timeout_o <= 1'b1;
            sample_en_o   <= 1'b0;
            state_q       <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpd_rail_ctrl.sv
module dpd_rail_ctrl
  import dpd_pkg::*;
#(
  parameter int          NUM_BANKS      = 2,
  parameter int          WORD_W         = 32,
  parameter int          RAIL_BITS      = 30,
  parameter longint      PCLK_HZ        = 100_000_000,
  parameter int          TIMEOUT_CYCLES = 25_000_000,
  parameter int          TIMER_W        = 16,
  localparam int         ID_W           = $clog2(NUM_BANKS * WORD_W) + 1,
  localparam int         FLAT_W         = NUM_BANKS * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ID_W-1:0]    req_id_i,
  input  logic               req_on_i,
  input  logic [FLAT_W-1:0]  status_flat_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_timeout_o,
  output logic               err_inval_o,
  output logic               sample_en_o,
  output logic [TIMER_W-1:0] dpd_timer_o,
  output logic [FLAT_W-1:0]  req_flat_o
);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int TIMER_VAL = min_hold_cycles(longint'(PCLK_HZ));

  logic [BANK_W-1:0] dec_bank, cur_bank;
  logic [BIT_W-1:0]  dec_bit, cur_bit;
  logic              dec_valid, wr, status_bit;
  logic [1:0]        cmd;

  dpd_id_decode #(
    .NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W), .RAIL_BITS(RAIL_BITS),
    .ID_W(ID_W), .BIT_W(BIT_W), .BANK_W(BANK_W)
  ) u_dec (
    .id_i(req_id_i), .bank_o(dec_bank), .bit_o(dec_bit), .valid_o(dec_valid)
  );

  assign status_bit = status_flat_i[{cur_bank, cur_bit}];

  dpd_seq #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .TIMER_W(TIMER_W), .TIMER_VAL(TIMER_VAL),
    .BIT_W(BIT_W), .BANK_W(BANK_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .id_valid_i(dec_valid),
    .bank_i(dec_bank), .bit_i(dec_bit), .on_i(req_on_i),
    .status_bit_i(status_bit),
    .cur_bank_o(cur_bank), .cur_bit_o(cur_bit), .cmd_o(cmd), .wr_o(wr),
    .busy_o(busy_o), .done_o(done_o), .err_timeout_o(err_timeout_o),
    .err_inval_o(err_inval_o), .sample_en_o(sample_en_o), .timer_o(dpd_timer_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dpd_bank_reg #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(wr && (int'(cur_bank) == b)),
      .bit_i(cur_bit), .cmd_i(cmd),
      .word_o(req_flat_o[b*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/dpd_rail_ctrl_chk.sv
module dpd_rail_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int WORD_W    = 32,
  parameter int TIMER_W   = 16,
  parameter int TIMER_VAL = 20
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        busy_o,
  input logic                        done_o,
  input logic                        err_timeout_o,
  input logic                        err_inval_o,
  input logic                        sample_en_o,
  input logic [TIMER_W-1:0]          dpd_timer_o,
  input logic [NUM_BANKS*WORD_W-1:0] req_flat_o
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_o, err_timeout_o, err_inval_o}) <= 1);  // R7

  AST_WORD_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(req_flat_o) |-> sample_en_o);  // R4

  AST_INVAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_inval_o |-> (!busy_o && $stable(req_flat_o)));  // R2

  AST_END_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_timeout_o) |-> (!busy_o && !sample_en_o));  // R8

  AST_TIMER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_o |-> (dpd_timer_o == TIMER_W'(TIMER_VAL)));  // R5

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_code
    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_flat_o[b*WORD_W+WORD_W-1 -: 2] != 2'b11);  // R3
  end
endmodule

bind dpd_rail_ctrl dpd_rail_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W), .TIMER_W(TIMER_W), .TIMER_VAL(TIMER_VAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .err_timeout_o(err_timeout_o), .err_inval_o(err_inval_o),
  .sample_en_o(sample_en_o), .dpd_timer_o(dpd_timer_o), .req_flat_o(req_flat_o)
);

// File: tb/dpd_rail_ctrl_test.sv
module dpd_rail_ctrl_test;
  localparam int T       = 40;
  localparam int EXP_TMR = 6;  // 30 MHz: ceil(1e9/3e7)=34 ns, ceil(200/34)=6
  localparam int NV      = 10;
  // {kind[1:0], on, lat[7:0], id[6:0]}; kind 0 done, 1 timeout, 2 invalid
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'd5,   7'd3},
    {2'd0, 1'b1, 8'd0,   7'd3},
    {2'd0, 1'b0, 8'd2,   7'd40},
    {2'd0, 1'b0, 8'd41,  7'd29},
    {2'd1, 1'b1, 8'd42,  7'd12},
    {2'd2, 1'b0, 8'd0,   7'd30},
    {2'd2, 1'b1, 8'd0,   7'd63},
    {2'd2, 1'b0, 8'd0,   7'd64},
    {2'd0, 1'b1, 8'd3,   7'd61},
    {2'd1, 1'b0, 8'd255, 7'd0}
  };

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_on = 0;
  logic [6:0]  req_id = 0;
  logic [63:0] stat = 0;
  logic        busy, done, to, inval, sample;
  logic [15:0] tmr;
  logic [63:0] words;
  logic [63:0] exp_words = 0;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dpd_rail_ctrl #(.PCLK_HZ(30_000_000), .TIMEOUT_CYCLES(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_id_i(req_id),
    .req_on_i(req_on), .status_flat_i(stat), .busy_o(busy), .done_o(done),
    .err_timeout_o(to), .err_inval_o(inval), .sample_en_o(sample),
    .dpd_timer_o(tmr), .req_flat_o(words)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [6:0] id, input logic on, input int lat,
                     input int kind, input bit poke);
    int n = 0, exp_n;
    bit ended = 0;
    logic tgt = ~on;
    logic [63:0] old = exp_words;
    if (kind == 2) exp_n = 1;
    else if (lat <= T + 1) exp_n = ((lat > 2) ? lat : 2) + 1;
    else exp_n = T + 2;
    @(negedge clk);
    if (kind != 2) stat[id] = (lat == 0) ? tgt : ~tgt;
    req_valid = 1; req_id = id; req_on = on;
    while (!ended && n < 300) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        req_valid = 0;
        if (kind != 2) begin
          chk("R8 busy after accept", 64'(busy), 64'd1);
          chk("R4 sample before write", 64'(sample), 64'd1);
          chk("R4 word unchanged before write", words, old);
          chk("R5 hold timer", 64'(tmr), 64'(EXP_TMR));
        end
      end
      if (poke && n == 3) begin req_valid = 1; req_id = 7'd33; req_on = 1; end
      if (poke && n == 4) req_valid = 0;
      if (done | to | inval) ended = 1;
      else if (n == lat) stat[id] = tgt;
    end
    if (kind != 2) begin
      exp_words[id] = 1'b1;
      exp_words[id[5] * 32 + 30 +: 2] = on ? 2'd1 : 2'd2;
    end
    chk(kind == 2 ? "R2 inval timing" : (kind == 1 ? "R7 timeout timing" : "R6 done timing"),
        64'(n), 64'(exp_n));
    chk("R7 outcome kind", {61'd0, inval, to, done}, 64'(1) << kind);
    chk("R1 R3 request words", words, exp_words);
    chk("R4 sample off at end", 64'(sample), 64'd0);
    chk("R8 busy off at end", 64'(busy), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #23;
    chk("R9 reset busy", 64'(busy), 64'd0);
    chk("R9 reset words", words, 64'd0);
    chk("R9 reset timer/sample", {47'd0, tmr, sample}, 64'd0);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      run(VEC[i][6:0], VEC[i][15], int'(VEC[i][14:7]), int'(VEC[i][17:16]), 1'b0);
    // R8: a request presented while busy is ignored
    run(7'd5, 1'b0, 10, 0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 ignored request no busy", 64'(busy | done | to | inval), 64'd0);
    end
    chk("R8 ignored request word", words, exp_words);
    // R9: reset during an operation clears everything
    @(negedge clk);
    req_valid = 1; req_id = 7'd7; req_on = 0; stat[7] = 0;
    @(negedge clk); req_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 0;
    #1;
    chk("R9 mid-op reset words", words, 64'd0);
    chk("R9 mid-op reset busy/sample", 64'({busy, sample}), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule